// File: doc/BRIEF.md
# Processor-Port Memory Bank Decoder

This block sits between an 8-bit CPU and the memory system of a machine with a 64 KB address space. It holds the CPU's on-chip I/O port, a data-direction register at address 0 and a data register at address 1. It turns the port's effective value into a bank map and decodes every CPU access to one target. The possible targets are main RAM, a BASIC ROM, a character ROM, a kernel ROM, or one of the I/O devices: video, sound, colour RAM, two timer/IO chips and an expansion unit.

The block holds the 1K x 4 colour RAM itself. It also answers reads of the port registers and of unmapped I/O space on its own. For those reads it builds the answer from the last byte seen on the video bus where needed.

Every access lasts one cycle: `cpu_rd` or `cpu_wr` is high for that cycle, and if both are high the access is a write. All decode outputs are registered, so they are valid during the cycle after the clock edge that sampled the access. Port register writes take effect at that same edge. The mapping for an access is taken from the port value before that edge.

Top module: `bank_decoder`

## Requirements
- R1: A synchronous reset clears the direction register, the data register and the latched output value. After reset, reading address 0 returns 0x00 and reading address 1 returns 0x17.
- R2: A write to address 0 loads the direction register and a write to address 1 loads the data register. A read of address 0 returns the direction register. Both writes also select RAM (tgt_sel bit 0), with `mem_wdata` equal to `vbus_last` and `mem_addr` equal to the written address.
- R3: A read of address 1 returns `eff & (latched | 0x17)`, where `eff = data | ~direction`. Bit 5 of the result is forced to 0 while direction bit 5 is 0.
- R4: On every port write, the latched output becomes `(latched & ~dir) | (data & dir)`, using the register values after that write. Bits whose direction is 0 keep their old latched value.
- R5: A read of 0xA000-0xBFFF selects the BASIC ROM (tgt_sel bit 1) with `rom_ofs` equal to addr[12:0] when eff[1:0] is 2'b11. Otherwise it selects RAM.
- R6: A read of 0xE000-0xFFFF selects the kernel ROM (tgt_sel bit 3) with `rom_ofs` equal to addr[12:0] when eff[1] is 1. Otherwise it selects RAM.
- R7: For 0xD000-0xDFFF, the region is RAM when eff[1:0] is 0. When eff[1:0] is nonzero, the region is I/O if eff[2] is 1. If eff[2] is 0, reads select the character ROM (tgt_sel bit 2) with `rom_ofs` equal to addr[11:0].
- R8: With I/O mapped, the region decodes as follows. 0xD000-0xD3FF selects video (bit 4, `dev_reg` = addr[5:0]). 0xD400-0xD7FF selects sound (bit 5, addr[4:0]). 0xDC00-0xDCFF selects timer/IO 1 (bit 7, addr[3:0]). 0xDD00-0xDDFF selects timer/IO 2 (bit 8, addr[3:0]). 0xDF00-0xDF0F selects the expansion unit (bit 9, addr[3:0]).
- R9: 0xD800-0xDBFF with I/O mapped selects the colour RAM (bit 6). A write stores wdata[3:0]. A read returns the stored nibble in bits [3:0] and `vbus_last[7:4]` in bits [7:4].
- R10: With I/O mapped, a read of 0xDE00-0xDFFF outside 0xDF00-0xDF0F selects no target and returns `vbus_last` on `loc_rdata` with `loc_valid` high.
- R11: Writes never select a ROM. Writes to 0xA000-0xBFFF, 0xE000-0xFFFF, and 0xD000-0xDFFF while I/O is unmapped select RAM. So does any access to 0x0002-0x9FFF or 0xC000-0xCFFF.
- R12: Outputs are registered with one cycle of latency. `tgt_sel` has at most one bit set. A cycle with no access leaves `tgt_sel` at zero and `loc_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| vbus_last | input | 8 | Last byte seen on the video bus |
| tgt_sel | output | 10 | One-hot target select (bit map in R2-R9) |
| acc_wr | output | 1 | The selected access is a write |
| mem_addr | output | 16 | Registered access address |
| mem_wdata | output | 8 | Write data for the selected target |
| rom_ofs | output | 13 | Offset inside the selected ROM |
| dev_reg | output | 6 | Register index for the selected I/O device |
| loc_valid | output | 1 | `loc_rdata` holds a locally produced read byte |
| loc_rdata | output | 8 | Port, colour RAM or open-bus read data |

## Verification
The assertions check the following on every cycle:
- `tgt_sel` is at most one-hot.
- A cycle with no access stays quiet.
- A write never reaches a ROM.
- A port write always shadows RAM with the video-bus byte.
- Reset clears the port registers.
- A direction write loads its register.

Other behaviour depends on value sequences, so only the directed scenarios can show it. This covers the retained latched bits across direction changes and the bit-5 masking on port reads. It also covers the full eight-value walk of the bank map and the colour RAM nibble merge with a changing video byte.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int ROM_OW = 13;
  localparam int REG_W  = 6;
  localparam int NT     = 10;

  localparam int T_RAM    = 0;
  localparam int T_BASIC  = 1;
  localparam int T_CHAR   = 2;
  localparam int T_KERNAL = 3;
  localparam int T_VIDEO  = 4;
  localparam int T_SOUND  = 5;
  localparam int T_COLOR  = 6;
  localparam int T_TIO1   = 7;
  localparam int T_TIO2   = 8;
  localparam int T_EXPN   = 9;

  typedef enum logic [2:0] {
    LK_NONE,
    LK_DIR,
    LK_PORT,
    LK_COLOR,
    LK_OPEN
  } loc_kind_e;
endpackage

// File: rtl/bank_port_regs.sv
module bank_port_regs
  import bank_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_dir,
  input  logic          wr_val,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ddr,
  output logic [DW-1:0] eff,
  output logic [DW-1:0] port_rd
);
  localparam logic [DW-1:0] PULL_MASK = DW'(8'h17);

  logic [DW-1:0] pval;
  logic [DW-1:0] latched;

  always_ff @(posedge clk) begin
    if (rst) begin
      ddr     <= '0;
      pval    <= '0;
      latched <= '0;
    end else if (wr_dir) begin
      ddr     <= wdata;
      latched <= (latched & ~wdata) | (pval & wdata);
    end else if (wr_val) begin
      pval    <= wdata;
      latched <= (latched & ~ddr) | (wdata & ddr);
    end
  end

  assign eff = pval | ~ddr;

  always_comb begin
    port_rd = eff & (latched | PULL_MASK);
    if (!ddr[5]) port_rd[5] = 1'b0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (ddr == '0 && eff == '1)); // R1

  AST_DIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> (ddr == $past(wdata))); // R2
endmodule

// File: rtl/bank_region_decode.sv
module bank_region_decode
  import bank_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic [AW-1:0]     addr,
  input  logic              rd,
  input  logic              wr,
  input  logic [DW-1:0]     eff,
  output logic [NT-1:0]     sel,
  output loc_kind_e         lk,
  output logic [ROM_OW-1:0] rom_ofs,
  output logic [REG_W-1:0]  dev_reg,
  output logic              shadow
);
  logic rd_e, basic_on, kern_on, io_on, chr_on;

  assign rd_e     = rd & ~wr;
  assign basic_on = (eff[1:0] == 2'b11);
  assign kern_on  = eff[1];
  assign io_on    = (|eff[1:0]) & eff[2];
  assign chr_on   = (|eff[1:0]) & ~eff[2];

  always_comb begin
    sel     = '0;
    lk      = LK_NONE;
    rom_ofs = '0;
    dev_reg = '0;
    shadow  = 1'b0;
    if (rd_e || wr) begin
      if (addr[AW-1:1] == '0) begin
        if (wr) begin
          sel[T_RAM] = 1'b1;
          shadow     = 1'b1;
        end else begin
          lk = addr[0] ? LK_PORT : LK_DIR;
        end
      end else begin
        case (addr[AW-1 -: 4])
          4'hA, 4'hB: begin
            if (rd_e && basic_on) begin
              sel[T_BASIC] = 1'b1;
              rom_ofs      = ROM_OW'(addr[12:0]);
            end else begin
              sel[T_RAM] = 1'b1;
            end
          end
          4'hE, 4'hF: begin
            if (rd_e && kern_on) begin
              sel[T_KERNAL] = 1'b1;
              rom_ofs       = ROM_OW'(addr[12:0]);
            end else begin
              sel[T_RAM] = 1'b1;
            end
          end
          4'hD: begin
            if (io_on) begin
              case (addr[11:10])
                2'b00: begin
                  sel[T_VIDEO] = 1'b1;
                  dev_reg      = REG_W'(addr[5:0]);
                end
                2'b01: begin
                  sel[T_SOUND] = 1'b1;
                  dev_reg      = REG_W'(addr[4:0]);
                end
                2'b10: begin
                  sel[T_COLOR] = 1'b1;
                  if (rd_e) lk = LK_COLOR;
                end
                default: begin
                  if (addr[9:8] == 2'b00) begin
                    sel[T_TIO1] = 1'b1;
                    dev_reg     = REG_W'(addr[3:0]);
                  end else if (addr[9:8] == 2'b01) begin
                    sel[T_TIO2] = 1'b1;
                    dev_reg     = REG_W'(addr[3:0]);
                  end else if (addr[9:4] == 6'h30) begin
                    sel[T_EXPN] = 1'b1;
                    dev_reg     = REG_W'(addr[3:0]);
                  end else if (rd_e) begin
                    lk = LK_OPEN;
                  end
                end
              endcase
            end else if (rd_e && chr_on) begin
              sel[T_CHAR] = 1'b1;
              rom_ofs     = ROM_OW'(addr[11:0]);
            end else begin
              sel[T_RAM] = 1'b1;
            end
          end
          default: sel[T_RAM] = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/bank_color_ram.sv
module bank_color_ram #(
  parameter int AW = 10,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/bank_decoder.sv
module bank_decoder
  import bank_pkg::*;
#(
  parameter int CRAM_AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [7:0]        vbus_last,
  output logic [NT-1:0]     tgt_sel,
  output logic              acc_wr,
  output logic [15:0]       mem_addr,
  output logic [7:0]        mem_wdata,
  output logic [ROM_OW-1:0] rom_ofs,
  output logic [REG_W-1:0]  dev_reg,
  output logic              loc_valid,
  output logic [7:0]        loc_rdata
);
  localparam int CW = DATA_W / 2;

  logic [DATA_W-1:0] ddr, eff, port_rd;
  logic [NT-1:0]     sel;
  loc_kind_e         lk, lk_q;
  logic [ROM_OW-1:0] rom_d;
  logic [REG_W-1:0]  reg_d;
  logic              shadow;
  logic [CW-1:0]     cram_q;
  logic [DATA_W-1:0] vbus_q, loc_byte_q;
  logic              port_wr;

  assign port_wr = cpu_wr && (cpu_addr[15:1] == '0);

  bank_port_regs #(.DW(DATA_W)) u_port (
    .clk     (clk),
    .rst     (rst),
    .wr_dir  (port_wr && !cpu_addr[0]),
    .wr_val  (port_wr && cpu_addr[0]),
    .wdata   (cpu_wdata),
    .ddr     (ddr),
    .eff     (eff),
    .port_rd (port_rd)
  );

  bank_region_decode #(.AW(ADDR_W), .DW(DATA_W)) u_dec (
    .addr    (cpu_addr),
    .rd      (cpu_rd),
    .wr      (cpu_wr),
    .eff     (eff),
    .sel     (sel),
    .lk      (lk),
    .rom_ofs (rom_d),
    .dev_reg (reg_d),
    .shadow  (shadow)
  );

  bank_color_ram #(.AW(CRAM_AW), .CW(CW)) u_cram (
    .clk   (clk),
    .we    (cpu_wr && sel[T_COLOR]),
    .addr  (cpu_addr[CRAM_AW-1:0]),
    .wdata (cpu_wdata[CW-1:0]),
    .rdata (cram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_sel    <= '0;
      acc_wr     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rom_ofs    <= '0;
      dev_reg    <= '0;
      lk_q       <= LK_NONE;
      vbus_q     <= '0;
      loc_byte_q <= '0;
    end else begin
      tgt_sel   <= sel;
      acc_wr    <= cpu_wr;
      mem_addr  <= cpu_addr;
      mem_wdata <= shadow ? vbus_last : cpu_wdata;
      rom_ofs   <= rom_d;
      dev_reg   <= reg_d;
      lk_q      <= lk;
      vbus_q    <= vbus_last;
      case (lk)
        LK_DIR:  loc_byte_q <= ddr;
        LK_PORT: loc_byte_q <= port_rd;
        default: loc_byte_q <= vbus_last;
      endcase
    end
  end

  assign loc_valid = (lk_q != LK_NONE);
  assign loc_rdata = (lk_q == LK_COLOR) ? {vbus_q[DATA_W-1:CW], cram_q} : loc_byte_q;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel)); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!cpu_rd && !cpu_wr) |=> (tgt_sel == '0 && !loc_valid)); // R12

  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    acc_wr |-> !(tgt_sel[T_BASIC] || tgt_sel[T_CHAR] || tgt_sel[T_KERNAL])); // R11

  AST_PORT_SHADOW: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr < 16'd2) |=> (tgt_sel[T_RAM] && mem_wdata == $past(vbus_last))); // R2
endmodule

// File: tb/bank_decoder_test.sv
module bank_decoder_test;
  localparam int CLK_PERIOD = 10;

  localparam int B_RAM = 0, B_BASIC = 1, B_CHAR = 2, B_KERNAL = 3, B_VIDEO = 4;
  localparam int B_SOUND = 5, B_COLOR = 6, B_TIO1 = 7, B_TIO2 = 8, B_EXPN = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  vbus_last = '0;
  logic [9:0]  tgt_sel;
  logic        acc_wr;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [12:0] rom_ofs;
  logic [5:0]  dev_reg;
  logic        loc_valid;
  logic [7:0]  loc_rdata;

  int checks = 0;
  int errors = 0;

  bank_decoder uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .vbus_last(vbus_last),
    .tgt_sel(tgt_sel), .acc_wr(acc_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rom_ofs(rom_ofs), .dev_reg(dev_reg),
    .loc_valid(loc_valid), .loc_rdata(loc_rdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [9:0] one(input int b);
    return 10'(1) << b;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic [15:0] a, input logic [7:0] d, input logic r, input logic w);
    cpu_addr = a; cpu_wdata = d; cpu_rd = r; cpu_wr = w;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic t_reset;
    acc(16'h0000, 8'h00, 1'b0, 1'b0);
    chk("R12 idle sel", 32'(tgt_sel), 32'(0));
    chk("R12 idle valid", 32'(loc_valid), 32'(0));
    acc(16'h0000, 8'h00, 1'b1, 1'b0);
    chk("R1 dir after reset", 32'({loc_valid, loc_rdata}), 32'(9'h100));
    acc(16'h0001, 8'h00, 1'b1, 1'b0);
    chk("R1 port after reset", 32'(loc_rdata), 32'(8'h17));
    chk("R1 port no target", 32'(tgt_sel), 32'(0));
    acc(16'hA000, 8'h00, 1'b1, 1'b0);
    chk("R5 basic default", 32'(tgt_sel), 32'(one(B_BASIC)));
    acc(16'hE123, 8'h00, 1'b1, 1'b0);
    chk("R6 kernal sel", 32'(tgt_sel), 32'(one(B_KERNAL)));
    chk("R6 kernal ofs", 32'(rom_ofs), 32'(13'h0123));
    acc(16'hD020, 8'h00, 1'b1, 1'b0);
    chk("R8 video default", 32'({tgt_sel, dev_reg}), 32'({one(B_VIDEO), 6'h20}));
    acc(16'hC000, 8'h00, 1'b1, 1'b0);
    chk("R11 C page ram", 32'(tgt_sel), 32'(one(B_RAM)));
  endtask

  task automatic t_port;
    vbus_last = 8'hA5;
    acc(16'h0000, 8'h08, 1'b0, 1'b1);
    chk("R2 dir write sel", 32'(tgt_sel), 32'(one(B_RAM)));
    chk("R2 dir write shadow", 32'(mem_wdata), 32'(8'hA5));
    chk("R2 dir write addr", 32'(mem_addr), 32'(0));
    acc(16'h0000, 8'h00, 1'b1, 1'b0);
    chk("R2 dir readback", 32'(loc_rdata), 32'(8'h08));
    acc(16'h0001, 8'hC8, 1'b0, 1'b1);
    chk("R2 data write shadow", 32'({mem_addr, mem_wdata}), 32'({16'h0001, 8'hA5}));
    acc(16'h0001, 8'h00, 1'b1, 1'b0);
    chk("R4 latch bit3 out", 32'(loc_rdata), 32'(8'h1F));
    acc(16'h0000, 8'h00, 1'b0, 1'b1);
    acc(16'h0001, 8'h00, 1'b1, 1'b0);
    chk("R4 latch kept after dir clear", 32'(loc_rdata), 32'(8'h1F));
    acc(16'h0001, 8'h00, 1'b0, 1'b1);
    acc(16'h0001, 8'h00, 1'b1, 1'b0);
    chk("R4 latch kept on input write", 32'(loc_rdata), 32'(8'h1F));
    acc(16'h0000, 8'h08, 1'b0, 1'b1);
    acc(16'h0001, 8'h00, 1'b1, 1'b0);
    chk("R4 latch reloaded", 32'(loc_rdata), 32'(8'h17));
    acc(16'h0000, 8'h20, 1'b0, 1'b1);
    acc(16'h0001, 8'h20, 1'b0, 1'b1);
    acc(16'h0001, 8'h00, 1'b1, 1'b0);
    chk("R3 bit5 driven", 32'(loc_rdata), 32'(8'h37));
    acc(16'h0000, 8'h00, 1'b0, 1'b1);
    acc(16'h0001, 8'h00, 1'b1, 1'b0);
    chk("R3 bit5 masked", 32'(loc_rdata), 32'(8'h17));
  endtask

  task automatic t_banks;
    logic [9:0] e;
    acc(16'h0000, 8'h07, 1'b0, 1'b1);
    for (int v = 0; v < 8; v++) begin
      acc(16'h0001, 8'(v), 1'b0, 1'b1);
      acc(16'hA123, 8'h00, 1'b1, 1'b0);
      e = ((v & 3) == 3) ? one(B_BASIC) : one(B_RAM);
      chk($sformatf("R5 v=%0d", v), 32'(tgt_sel), 32'(e));
      acc(16'hF456, 8'h00, 1'b1, 1'b0);
      e = ((v & 2) != 0) ? one(B_KERNAL) : one(B_RAM);
      chk($sformatf("R6 v=%0d", v), 32'(tgt_sel), 32'(e));
      acc(16'hD456, 8'h00, 1'b1, 1'b0);
      if ((v & 3) == 0) begin
        chk($sformatf("R7 ram v=%0d", v), 32'(tgt_sel), 32'(one(B_RAM)));
      end else if ((v & 4) != 0) begin
        chk($sformatf("R7 io v=%0d", v), 32'({tgt_sel, dev_reg}), 32'({one(B_SOUND), 6'h16}));
      end else begin
        chk($sformatf("R7 char v=%0d", v), 32'({tgt_sel, rom_ofs}), 32'({one(B_CHAR), 13'h0456}));
      end
    end
  endtask

  task automatic t_writes;
    acc(16'h0001, 8'h03, 1'b0, 1'b1);
    acc(16'hA123, 8'h11, 1'b0, 1'b1);
    chk("R11 basic write ram", 32'({tgt_sel, acc_wr}), 32'({one(B_RAM), 1'b1}));
    chk("R11 basic write data", 32'(mem_wdata), 32'(8'h11));
    acc(16'hE000, 8'h22, 1'b0, 1'b1);
    chk("R11 kernal write ram", 32'(tgt_sel), 32'(one(B_RAM)));
    acc(16'hD456, 8'h33, 1'b0, 1'b1);
    chk("R11 char write ram", 32'(tgt_sel), 32'(one(B_RAM)));
    acc(16'h0001, 8'h07, 1'b0, 1'b1);
    acc(16'hD020, 8'h44, 1'b0, 1'b1);
    chk("R8 video write", 32'({tgt_sel, acc_wr}), 32'({one(B_VIDEO), 1'b1}));
    acc(16'hE000, 8'h55, 1'b0, 1'b1);
    chk("R11 kernal write io map", 32'(tgt_sel), 32'(one(B_RAM)));
  endtask

  task automatic t_io;
    vbus_last = 8'h5C;
    acc(16'hD3FF, 8'h00, 1'b1, 1'b0);
    chk("R8 video mask", 32'({tgt_sel, dev_reg}), 32'({one(B_VIDEO), 6'h3F}));
    acc(16'hD7FF, 8'h00, 1'b1, 1'b0);
    chk("R8 sound mask", 32'({tgt_sel, dev_reg}), 32'({one(B_SOUND), 6'h1F}));
    acc(16'hDCFF, 8'h00, 1'b1, 1'b0);
    chk("R8 tio1", 32'({tgt_sel, dev_reg}), 32'({one(B_TIO1), 6'h0F}));
    acc(16'hDD05, 8'h00, 1'b1, 1'b0);
    chk("R8 tio2", 32'({tgt_sel, dev_reg}), 32'({one(B_TIO2), 6'h05}));
    acc(16'hDF0A, 8'h00, 1'b1, 1'b0);
    chk("R8 expansion", 32'({tgt_sel, dev_reg}), 32'({one(B_EXPN), 6'h0A}));
    acc(16'hDF10, 8'h00, 1'b1, 1'b0);
    chk("R10 open DF10", 32'({tgt_sel, loc_valid, loc_rdata}), 32'({10'd0, 1'b1, 8'h5C}));
    vbus_last = 8'hE1;
    acc(16'hDE00, 8'h00, 1'b1, 1'b0);
    chk("R10 open DE00", 32'({tgt_sel, loc_valid, loc_rdata}), 32'({10'd0, 1'b1, 8'hE1}));
    acc(16'hDE40, 8'h77, 1'b0, 1'b1);
    chk("R10 open write none", 32'(tgt_sel), 32'(0));
  endtask

  task automatic t_color;
    acc(16'hD800, 8'hAB, 1'b0, 1'b1);
    chk("R9 color write sel", 32'(tgt_sel), 32'(one(B_COLOR)));
    acc(16'hDBFF, 8'h35, 1'b0, 1'b1);
    vbus_last = 8'h90;
    acc(16'hD800, 8'h00, 1'b1, 1'b0);
    chk("R9 color read D800", 32'({tgt_sel, loc_valid, loc_rdata}), 32'({one(B_COLOR), 1'b1, 8'h9B}));
    acc(16'hDBFF, 8'h00, 1'b1, 1'b0);
    chk("R9 color read DBFF", 32'(loc_rdata), 32'(8'h95));
    vbus_last = 8'h60;
    acc(16'hD800, 8'h00, 1'b1, 1'b0);
    chk("R9 color new vbus", 32'(loc_rdata), 32'(8'h6B));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired got=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_port();
    t_banks();
    t_writes();
    t_io();
    t_color();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule